// File: doc/BRIEF.md
# Peripheral I/O Register Bank

This block is a halfword-organised register bank that sits between a processor bus and a group of peripherals: display, sound, DMA, timers, keypad, interrupt flags and power control. It takes byte, halfword and word writes and halfword reads on a small byte-addressed window. It keeps the register contents and applies each register's own write rule. In the same cycle that it accepts a write, it raises strobes that carry the committed values out to the peripherals.

Some registers do not read back what was stored. Instead they reflect a live value from a peripheral: a timer's running count, the pressed keys, or video status bits. The peripherals themselves are not part of the block. Registers that hold a 32-bit quantity are collected into a run of "wide" words. A write to either half of a wide word commits the full 32-bit value on one channel strobe. Reads are combinational. Writes commit on the rising clock edge.

Top module: `iob_regbank`

## Requirements
- R1: After reset, the halfword at byte 0x000 reads 0x0080, the key register at 0x0A0 reads 0x03FF while no key is pressed, and every other stored halfword (for example 0x010 and the flag register at 0x0B2) reads 0x0000.
- R2: A halfword write to a plain address is stored and reads back unchanged. In the same cycle, cmt_we raises bit wr_addr[1] and carries the value in the matching half of cmt_data (bits 15:0 for bit 0, bits 31:16 for bit 1), with cmt_addr set to the 4-byte aligned address.
- R3: The flag register at 0x0B2 takes a written value as a clear mask: the stored value becomes old AND NOT data. Every cycle, each bit set on irq_set is ORed in, and this OR wins over a clear of the same bit in the same cycle.
- R4: A byte write (wr_size 0) places wr_data[7:0] in the low byte of its halfword when wr_addr[0] is 0 and in the high byte when it is 1. The other byte keeps its stored value, and the merged halfword follows the halfword rules of its address.
- R5: A word write (wr_size 2) to an address that is not a wide word stores wr_data[15:0] at the aligned address and wr_data[31:16] at aligned+2. cmt_we is 2'b11 in that cycle.
- R6: Byte addresses 0x040 to 0x05F form wide words, channel n at 0x040+4n. Any write there raises only wide_we[n], carrying the 32-bit value built from the written half or halves and the stored other half. cmt_we stays 0, and both halves read back as stored.
- R7: A write to the timer reload address 0x080+4n pulses tmr_reload_we[n] with the written value in tmr_reload_val. The value is not stored and raises no cmt_we bit. A read of that address returns tmr_count[n] live.
- R8: A write to the timer control address 0x082+4n is masked with 0x00C7. The masked value is stored, read back and carried on cmt_data.
- R9: The DMA count-low addresses 0x060+4n are write-only and read 0x0000. The addresses at 0x062+4n are plain storage.
- R10: A read of 0x0A0 returns 0x03FF XOR key_pressed, zero-extended, whatever was written there.
- R11: A read of 0x004 returns the stored value ORed with vid_status.
- R12: A byte write to 0x0C1 is never stored and raises no cmt_we bit. For one cycle it raises halt_req when wr_data[7] is 0 and stop_req when it is 1. Every read of 0x0C0 returns 0x0000, and no other write to halfword 0x0C0 has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write accepted this cycle |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data, low-aligned for byte and halfword |
| rd_addr | input | ADDR_W | Byte address of the halfword read |
| rd_data | output | 16 | Read data, combinational |
| vid_status | input | 16 | Live video status bits |
| key_pressed | input | KEY_BITS | Pressed-key bitmap, 1 means pressed |
| tmr_count | input | NUM_TMR x 16 | Live timer counts |
| irq_set | input | 16 | Flag bits raised by peripherals |
| cmt_we | output | 2 | Per-halfword commit strobes |
| cmt_addr | output | ADDR_W | Aligned address of the commit |
| cmt_data | output | 32 | Committed halfword values |
| wide_we | output | NUM_WIDE | Wide-word channel commit strobes |
| wide_data | output | 32 | Committed wide-word value |
| tmr_reload_we | output | NUM_TMR | Timer reload strobes |
| tmr_reload_val | output | 16 | Timer reload value |
| halt_req | output | 1 | One-cycle halt request |
| stop_req | output | 1 | One-cycle stop request |

## Verification
The hardest state to reach from the ports is a flag register with bits set. Writes can only clear that register, so the bench first raises bits through irq_set. It then clears a subset by a write, and finally sets and clears the same bit in one cycle. The combining of a wide word's halves is also hard to reach, because it needs a stored other half. The bench writes one half, then the other, then one byte inside the first half, and checks the whole 32-bit value on the channel strobe each time.

// File: rtl/iob_pkg.sv
`timescale 1ns/1ps
package iob_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } wsize_e;

   typedef enum logic [3:0] {
      K_PLAIN, K_DSTAT, K_WIDE, K_WONLY, K_TRELOAD,
      K_TCTRL, K_KEYS, K_IRQF, K_HALT
   } kind_e;

   localparam int CH_W = 5;

   typedef struct packed {
      kind_e           kind;
      logic [CH_W-1:0] chan;
   } cls_t;
endpackage

// File: rtl/iob_decode.sv
`timescale 1ns/1ps
module iob_decode
   import iob_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DSTAT_A   = 'h004,
   parameter int WIDE_BASE = 'h040,
   parameter int NUM_WIDE  = 8,
   parameter int DCNT_BASE = 'h060,
   parameter int NUM_DMA   = 4,
   parameter int TMR_BASE  = 'h080,
   parameter int NUM_TMR   = 4,
   parameter int KEY_A     = 'h0A0,
   parameter int IRQF_A    = 'h0B2,
   parameter int HALT_A    = 'h0C1
) (
   input  logic [ADDR_W-2:0] hw_idx,
   output cls_t              cls
);
   localparam int WIDE_END = WIDE_BASE + 4 * NUM_WIDE;
   localparam int DCNT_END = DCNT_BASE + 4 * NUM_DMA;
   localparam int TMR_END  = TMR_BASE + 4 * NUM_TMR;
   localparam int HALT_HW  = HALT_A & ~1;

   int a;

   always_comb begin
      a        = int'({hw_idx, 1'b0});
      cls.kind = K_PLAIN;
      cls.chan = '0;
      if (a >= WIDE_BASE && a < WIDE_END) begin
         cls.kind = K_WIDE;
         cls.chan = CH_W'((a - WIDE_BASE) >> 2);
      end else if (a >= TMR_BASE && a < TMR_END) begin
         cls.kind = ((a % 4) == 0) ? K_TRELOAD : K_TCTRL;
         cls.chan = CH_W'((a - TMR_BASE) >> 2);
      end else if (a >= DCNT_BASE && a < DCNT_END && (a % 4) == 0) begin
         cls.kind = K_WONLY;
      end else if (a == DSTAT_A) begin
         cls.kind = K_DSTAT;
      end else if (a == KEY_A) begin
         cls.kind = K_KEYS;
      end else if (a == IRQF_A) begin
         cls.kind = K_IRQF;
      end else if (a == HALT_HW) begin
         cls.kind = K_HALT;
      end
   end
endmodule

// File: rtl/iob_lane.sv
`timescale 1ns/1ps
module iob_lane
   import iob_pkg::*;
#(
   parameter int TMR_MASK = 'h00C7
) (
   input  logic        act,
   input  kind_e       kind,
   input  wsize_e      size,
   input  logic        byte_hi,
   input  logic [15:0] raw,
   input  logic [15:0] old,
   output logic [15:0] val,
   output logic [15:0] commit,
   output logic        store_en,
   output logic        cmt_en,
   output logic        reload_en,
   output logic        wide_en
);
   logic storable;

   always_comb begin
      if (size == SZ_BYTE)
         val = byte_hi ? {raw[7:0], old[7:0]} : {old[15:8], raw[7:0]};
      else
         val = raw;
   end

   always_comb begin
      case (kind)
         K_TCTRL: commit = val & 16'(TMR_MASK);
         K_IRQF:  commit = old & ~val;
         default: commit = val;
      endcase
   end

   assign storable  = (kind != K_TRELOAD) && (kind != K_HALT);
   assign store_en  = act && storable;
   assign cmt_en    = act && storable && (kind != K_WIDE);
   assign reload_en = act && (kind == K_TRELOAD);
   assign wide_en   = act && (kind == K_WIDE);
endmodule

// File: rtl/iob_read_mux.sv
`timescale 1ns/1ps
module iob_read_mux
   import iob_pkg::*;
#(
   parameter int NUM_TMR  = 4,
   parameter int KEY_BITS = 10
) (
   input  cls_t                     cls,
   input  logic [15:0]              old,
   input  logic [15:0]              vid_status,
   input  logic [KEY_BITS-1:0]      key_pressed,
   input  logic [NUM_TMR-1:0][15:0] tmr_count,
   output logic [15:0]              rd_data
);
   localparam logic [15:0] KEY_MASK = 16'((1 << KEY_BITS) - 1);

   always_comb begin
      case (cls.kind)
         K_WONLY, K_HALT: rd_data = 16'h0000;
         K_TRELOAD: begin
            rd_data = 16'h0000;
            for (int i = 0; i < NUM_TMR; i++)
               if (int'(cls.chan) == i) rd_data = tmr_count[i];
         end
         K_KEYS:  rd_data = KEY_MASK ^ 16'(key_pressed);
         K_DSTAT: rd_data = old | vid_status;
         default: rd_data = old;
      endcase
   end
endmodule

// File: rtl/iob_regbank.sv
`timescale 1ns/1ps
module iob_regbank
   import iob_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DCTRL_A   = 'h000,
   parameter int DCTRL_RST = 'h0080,
   parameter int DSTAT_A   = 'h004,
   parameter int WIDE_BASE = 'h040,
   parameter int NUM_WIDE  = 8,
   parameter int DCNT_BASE = 'h060,
   parameter int NUM_DMA   = 4,
   parameter int TMR_BASE  = 'h080,
   parameter int NUM_TMR   = 4,
   parameter int TMR_MASK  = 'h00C7,
   parameter int KEY_A     = 'h0A0,
   parameter int KEY_BITS  = 10,
   parameter int IRQF_A    = 'h0B2,
   parameter int HALT_A    = 'h0C1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_size,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [31:0]              wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [15:0]              rd_data,
   input  logic [15:0]              vid_status,
   input  logic [KEY_BITS-1:0]      key_pressed,
   input  logic [NUM_TMR-1:0][15:0] tmr_count,
   input  logic [15:0]              irq_set,
   output logic [1:0]               cmt_we,
   output logic [ADDR_W-1:0]        cmt_addr,
   output logic [31:0]              cmt_data,
   output logic [NUM_WIDE-1:0]      wide_we,
   output logic [31:0]              wide_data,
   output logic [NUM_TMR-1:0]       tmr_reload_we,
   output logic [15:0]              tmr_reload_val,
   output logic                     halt_req,
   output logic                     stop_req
);
   localparam int          HW_W     = ADDR_W - 1;
   localparam int          NUM_HW   = 1 << HW_W;
   localparam int          DCTRL_HW = DCTRL_A / 2;
   localparam int          KEY_HW   = KEY_A / 2;
   localparam int          IRQF_HW  = IRQF_A / 2;
   localparam logic [15:0] KEY_MASK = 16'((1 << KEY_BITS) - 1);

   initial begin
      assert (ADDR_W >= 4 && ADDR_W <= 12) else $error("iob_regbank: ADDR_W out of range");
      assert (WIDE_BASE % 4 == 0 && TMR_BASE % 4 == 0 && DCNT_BASE % 4 == 0)
         else $error("iob_regbank: region bases must be word aligned");
      assert (NUM_WIDE >= 1 && NUM_WIDE <= (1 << CH_W)) else $error("iob_regbank: NUM_WIDE");
      assert (NUM_TMR >= 1 && NUM_TMR <= (1 << CH_W)) else $error("iob_regbank: NUM_TMR");
      assert (KEY_BITS >= 1 && KEY_BITS <= 16) else $error("iob_regbank: KEY_BITS");
      assert (WIDE_BASE + 4 * NUM_WIDE <= (1 << ADDR_W) && TMR_BASE + 4 * NUM_TMR <= (1 << ADDR_W))
         else $error("iob_regbank: region exceeds window");
      assert (IRQF_A % 2 == 0 && KEY_A % 2 == 0 && DSTAT_A % 2 == 0 && DCTRL_A % 2 == 0)
         else $error("iob_regbank: halfword registers must be even");
   end

   logic [15:0] mem [NUM_HW];

   wsize_e sz;
   logic   halt_byte;

   assign sz        = wsize_e'(wr_size);
   assign halt_byte = wr_en && (sz == SZ_BYTE) && (wr_addr == ADDR_W'(HALT_A));
   assign halt_req  = halt_byte && !wr_data[7];
   assign stop_req  = halt_byte && wr_data[7];

   // Two halfword lanes of the aligned word: lane l serves address bit 1 == l
   logic [HW_W-1:0] ln_hw     [2];
   logic [15:0]     ln_raw    [2];
   logic [15:0]     ln_old    [2];
   logic [15:0]     ln_val    [2];
   logic [15:0]     ln_commit [2];
   cls_t            ln_cls    [2];
   logic [1:0]      ln_act, ln_store, ln_cmt, ln_reload, ln_wide;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      assign ln_hw[l]  = {wr_addr[ADDR_W-1:2], 1'(l)};
      assign ln_old[l] = mem[ln_hw[l]];
      assign ln_raw[l] = (l == 1 && sz == SZ_WORD) ? wr_data[31:16] : wr_data[15:0];
      assign ln_act[l] = wr_en && !halt_byte &&
                         ((sz == SZ_WORD) || (wr_addr[1] == 1'(l)));

      iob_decode #(
         .ADDR_W(ADDR_W), .DSTAT_A(DSTAT_A), .WIDE_BASE(WIDE_BASE), .NUM_WIDE(NUM_WIDE),
         .DCNT_BASE(DCNT_BASE), .NUM_DMA(NUM_DMA), .TMR_BASE(TMR_BASE), .NUM_TMR(NUM_TMR),
         .KEY_A(KEY_A), .IRQF_A(IRQF_A), .HALT_A(HALT_A)
      ) u_dec (
         .hw_idx (ln_hw[l]),
         .cls    (ln_cls[l])
      );

      iob_lane #(.TMR_MASK(TMR_MASK)) u_lane (
         .act       (ln_act[l]),
         .kind      (ln_cls[l].kind),
         .size      (sz),
         .byte_hi   (wr_addr[0]),
         .raw       (ln_raw[l]),
         .old       (ln_old[l]),
         .val       (ln_val[l]),
         .commit    (ln_commit[l]),
         .store_en  (ln_store[l]),
         .cmt_en    (ln_cmt[l]),
         .reload_en (ln_reload[l]),
         .wide_en   (ln_wide[l])
      );
   end

   // Halfword commit strobes
   assign cmt_we   = ln_cmt;
   assign cmt_addr = {wr_addr[ADDR_W-1:2], 2'b00};
   assign cmt_data = {ln_commit[1], ln_commit[0]};

   // Wide-word commit: both lanes of a wide word share one channel
   logic [CH_W-1:0] wide_ch;
   assign wide_ch   = ln_wide[0] ? ln_cls[0].chan : ln_cls[1].chan;
   assign wide_data = {ln_wide[1] ? ln_commit[1] : ln_old[1],
                       ln_wide[0] ? ln_commit[0] : ln_old[0]};

   always_comb begin
      wide_we = '0;
      for (int i = 0; i < NUM_WIDE; i++)
         if ((|ln_wide) && int'(wide_ch) == i) wide_we[i] = 1'b1;
   end

   // Timer reload: forwarded, never stored
   always_comb begin
      tmr_reload_we  = '0;
      tmr_reload_val = ln_val[0];
      for (int l = 0; l < 2; l++) begin
         if (ln_reload[l]) begin
            tmr_reload_val = ln_val[l];
            for (int i = 0; i < NUM_TMR; i++)
               if (int'(ln_cls[l].chan) == i) tmr_reload_we[i] = 1'b1;
         end
      end
   end

   // Flag register clear mask from whichever lane hit it
   logic        irq_hit;
   logic [15:0] irq_clr;
   always_comb begin
      irq_hit = 1'b0;
      irq_clr = 16'h0000;
      for (int l = 0; l < 2; l++) begin
         if (ln_store[l] && ln_cls[l].kind == K_IRQF) begin
            irq_hit = 1'b1;
            irq_clr = ln_val[l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_HW; i++) begin
            if (i == DCTRL_HW)    mem[i] <= 16'(DCTRL_RST);
            else if (i == KEY_HW) mem[i] <= KEY_MASK;
            else                  mem[i] <= 16'h0000;
         end
      end else begin
         for (int l = 0; l < 2; l++)
            if (ln_store[l]) mem[ln_hw[l]] <= ln_commit[l];
         mem[IRQF_HW] <= (mem[IRQF_HW] & ~irq_clr) | irq_set;
      end
   end

   // Read side
   cls_t rd_cls;
   iob_decode #(
      .ADDR_W(ADDR_W), .DSTAT_A(DSTAT_A), .WIDE_BASE(WIDE_BASE), .NUM_WIDE(NUM_WIDE),
      .DCNT_BASE(DCNT_BASE), .NUM_DMA(NUM_DMA), .TMR_BASE(TMR_BASE), .NUM_TMR(NUM_TMR),
      .KEY_A(KEY_A), .IRQF_A(IRQF_A), .HALT_A(HALT_A)
   ) u_rd_dec (
      .hw_idx (rd_addr[ADDR_W-1:1]),
      .cls    (rd_cls)
   );

   iob_read_mux #(.NUM_TMR(NUM_TMR), .KEY_BITS(KEY_BITS)) u_rd_mux (
      .cls         (rd_cls),
      .old         (mem[rd_addr[ADDR_W-1:1]]),
      .vid_status  (vid_status),
      .key_pressed (key_pressed),
      .tmr_count   (tmr_count),
      .rd_data     (rd_data)
   );

   // Assertions
   p_rst_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mem[DCTRL_HW] == 16'(DCTRL_RST) && mem[KEY_HW] == KEY_MASK));

   p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hit |=> ((mem[IRQF_HW] & $past(irq_clr) & ~$past(irq_set)) == 16'h0000));

   p_wide_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wide_we));

   p_wide_no_cmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|wide_we) && (wr_size == 2'd2) |-> (cmt_we == 2'b00));

   p_reload_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tmr_reload_we));

   p_halt_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_req && stop_req));

   p_halt_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req || stop_req) |-> (wr_en && wr_size == 2'd0 && cmt_we == 2'b00));
endmodule

// File: tb/iob_regbank_tb.sv
`timescale 1ns/1ps
module iob_regbank_tb;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_size = 2'd1;
   logic [7:0]        wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [7:0]        rd_addr = '0;
   logic [15:0]       rd_data;
   logic [15:0]       vid_status = '0;
   logic [9:0]        key_pressed = '0;
   logic [3:0][15:0]  tmr_count = '0;
   logic [15:0]       irq_set = '0;
   logic [1:0]        cmt_we;
   logic [7:0]        cmt_addr;
   logic [31:0]       cmt_data;
   logic [7:0]        wide_we;
   logic [31:0]       wide_data;
   logic [3:0]        tmr_reload_we;
   logic [15:0]       tmr_reload_val;
   logic              halt_req, stop_req;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   iob_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .vid_status(vid_status),
      .key_pressed(key_pressed), .tmr_count(tmr_count), .irq_set(irq_set),
      .cmt_we(cmt_we), .cmt_addr(cmt_addr), .cmt_data(cmt_data), .wide_we(wide_we),
      .wide_data(wide_data), .tmr_reload_we(tmr_reload_we), .tmr_reload_val(tmr_reload_val),
      .halt_req(halt_req), .stop_req(stop_req)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr_go(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_size = sz; wr_addr = a; wr_data = d;
      #1;
   endtask

   task automatic wr_done();
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
      rd_addr = a;
      #1;
      chk(tag, {16'h0, rd_data}, {16'h0, exp});
   endtask

   task automatic t_reset();
      rd_chk("R1 disp ctrl reset", 8'h00, 16'h0080);
      rd_chk("R1 key reset", 8'hA0, 16'h03FF);
      rd_chk("R1 plain reset", 8'h10, 16'h0000);
      rd_chk("R1 flag reset", 8'hB2, 16'h0000);
   endtask

   task automatic t_plain();
      wr_go(2'd1, 8'h12, 32'h0000_5A5A);
      chk("R2 cmt_we", {30'h0, cmt_we}, 32'h2);
      chk("R2 cmt_addr", {24'h0, cmt_addr}, 32'h10);
      chk("R2 cmt_data hi", {16'h0, cmt_data[31:16]}, 32'h5A5A);
      wr_done();
      rd_chk("R2 readback", 8'h12, 16'h5A5A);
   endtask

   task automatic t_byte();
      wr_go(2'd0, 8'h12, 32'h0000_0077);
      wr_done();
      rd_chk("R4 low byte merge", 8'h12, 16'h5A77);
      wr_go(2'd0, 8'h13, 32'h0000_0011);
      chk("R4 byte cmt lane", {30'h0, cmt_we}, 32'h2);
      wr_done();
      rd_chk("R4 high byte merge", 8'h12, 16'h1177);
   endtask

   task automatic t_word();
      wr_go(2'd2, 8'h20, 32'hCAFE_F00D);
      chk("R5 both lanes", {30'h0, cmt_we}, 32'h3);
      chk("R5 cmt data", cmt_data, 32'hCAFE_F00D);
      wr_done();
      rd_chk("R5 low half", 8'h20, 16'hF00D);
      rd_chk("R5 high half", 8'h22, 16'hCAFE);
   endtask

   task automatic t_flags();
      @(negedge clk); irq_set = 16'h00F0;
      @(negedge clk); irq_set = 16'h0000;
      rd_chk("R3 flags raised", 8'hB2, 16'h00F0);
      wr_go(2'd1, 8'hB2, 32'h0000_0030);
      chk("R3 cmt carries result", {16'h0, cmt_data[31:16]}, 32'h00C0);
      wr_done();
      rd_chk("R3 write one clears", 8'hB2, 16'h00C0);
      wr_go(2'd1, 8'hB2, 32'h0000_0040);
      irq_set = 16'h0040;
      wr_done();
      irq_set = 16'h0000;
      rd_chk("R3 set beats clear", 8'hB2, 16'h00C0);
   endtask

   task automatic t_wide();
      wr_go(2'd1, 8'h44, 32'h0000_AAAA);
      chk("R6 chan1 strobe", {24'h0, wide_we}, 32'h02);
      chk("R6 low half commit", wide_data, 32'h0000_AAAA);
      chk("R6 no cmt", {30'h0, cmt_we}, 32'h0);
      wr_done();
      wr_go(2'd1, 8'h46, 32'h0000_BBBB);
      chk("R6 combine other half", wide_data, 32'hBBBB_AAAA);
      wr_done();
      wr_go(2'd0, 8'h45, 32'h0000_00CC);
      chk("R6 byte into wide", wide_data, 32'hBBBB_CCAA);
      wr_done();
      wr_go(2'd2, 8'h5C, 32'h1234_5678);
      chk("R6 chan7 word strobe", {24'h0, wide_we}, 32'h80);
      chk("R6 word commit", wide_data, 32'h1234_5678);
      chk("R6 word no cmt", {30'h0, cmt_we}, 32'h0);
      wr_done();
      rd_chk("R6 readback", 8'h5E, 16'h1234);
   endtask

   task automatic t_timer();
      tmr_count[2] = 16'h2468;
      wr_go(2'd1, 8'h88, 32'h0000_BEEF);
      chk("R7 reload strobe", {28'h0, tmr_reload_we}, 32'h4);
      chk("R7 reload value", {16'h0, tmr_reload_val}, 32'hBEEF);
      chk("R7 reload not committed", {30'h0, cmt_we}, 32'h0);
      wr_done();
      rd_chk("R7 live count", 8'h88, 16'h2468);
      tmr_count[2] = 16'h2469;
      rd_chk("R7 count follows", 8'h88, 16'h2469);
      wr_go(2'd1, 8'h8A, 32'h0000_FFFF);
      chk("R8 masked cmt", {16'h0, cmt_data[31:16]}, 32'h00C7);
      wr_done();
      rd_chk("R8 masked store", 8'h8A, 16'h00C7);
      wr_go(2'd2, 8'h80, 32'h0F38_1111);
      chk("R7 word reload strobe", {28'h0, tmr_reload_we}, 32'h1);
      chk("R7 word reload value", {16'h0, tmr_reload_val}, 32'h1111);
      chk("R8 word ctrl lane only", {30'h0, cmt_we}, 32'h2);
      chk("R8 word ctrl masked", {16'h0, cmt_data[31:16]}, 32'h0000);
      wr_done();
   endtask

   task automatic t_dma();
      wr_go(2'd1, 8'h64, 32'h0000_1234);
      wr_done();
      rd_chk("R9 count low reads zero", 8'h64, 16'h0000);
      wr_go(2'd1, 8'h66, 32'h0000_8000);
      wr_done();
      rd_chk("R9 count high plain", 8'h66, 16'h8000);
   endtask

   task automatic t_keys();
      key_pressed = 10'h005;
      rd_chk("R10 pressed reads zero", 8'hA0, 16'h03FA);
      wr_go(2'd1, 8'hA0, 32'h0000_0000);
      wr_done();
      key_pressed = 10'h200;
      rd_chk("R10 write has no effect", 8'hA0, 16'h01FF);
      key_pressed = 10'h000;
   endtask

   task automatic t_dstat();
      wr_go(2'd1, 8'h04, 32'h0000_0F00);
      wr_done();
      vid_status = 16'h0003;
      rd_chk("R11 stored or live", 8'h04, 16'h0F03);
      vid_status = 16'h0000;
   endtask

   task automatic t_halt();
      wr_go(2'd0, 8'hC1, 32'h0000_0000);
      chk("R12 halt raised", {31'h0, halt_req}, 32'h1);
      chk("R12 no stop", {31'h0, stop_req}, 32'h0);
      chk("R12 no cmt", {30'h0, cmt_we}, 32'h0);
      wr_done();
      chk("R12 halt one cycle", {31'h0, halt_req}, 32'h0);
      wr_go(2'd0, 8'hC1, 32'h0000_00FF);
      chk("R12 stop raised", {31'h0, stop_req}, 32'h1);
      chk("R12 stop excludes halt", {31'h0, halt_req}, 32'h0);
      wr_done();
      wr_go(2'd0, 8'hC0, 32'h0000_0000);
      chk("R12 even byte no halt", {31'h0, halt_req}, 32'h0);
      wr_done();
      wr_go(2'd1, 8'hC0, 32'h0000_9999);
      wr_done();
      rd_chk("R12 never stored", 8'hC0, 16'h0000);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      tmr_count[0] = 16'h1357;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_byte();
      t_word();
      t_flags();
      t_wide();
      t_timer();
      t_dma();
      t_keys();
      t_dstat();
      t_halt();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule